// File: doc/BRIEF.md
# Multi-Lane Byte Stream Merger

This block sits in a camera link receiver behind the per-lane deserializers. Each of up to eight lanes delivers already word-aligned bytes on a shared byte clock, each byte qualified by a valid bit. A packet is striped across the active lanes one byte at a time in rotating order. Every active lane marks its first byte of the packet with a first flag and its final byte with a last flag. The merger puts each lane's bytes into a small buffer of its own, starting at that lane's first byte. This removes the skew between lanes. It then reads the buffers back in rotation to rebuild the original byte order, one byte per cycle, behind a ready/valid output.

A controller with four states runs the merge. **IDLE** waits for a first byte on any active lane. If all active lanes start in the same cycle it moves straight to **STREAM**. If the skew window is zero and only some lanes start, it moves to **DROP**. Otherwise it moves to **SYNC**. **SYNC** counts the cycles since the earliest start. It moves to **STREAM** once every active lane has started, or to **DROP** when the count reaches the programmed window first. **STREAM** sends the merged bytes and returns to **IDLE** when the final byte is accepted. **DROP** empties the buffers, discards incoming bytes and pulses the alignment error. It returns to **IDLE** once every lane that did start has delivered its last flag.

The output marks the first byte of a packet with a start flag and the final byte with an end flag. When the packet length is not a multiple of the lane count, the trailing lanes carry one byte fewer. The merger detects the end from the first lane in rotation that is exhausted, and it never waits for a byte that will not come.

Top module: `lane_merger`

## Requirements
- R1: Only lanes 0 to cfg_lanes-1 take part (cfg_lanes from 1 to 8). Valid bytes and flags on higher lanes have no effect on the output, and a single active lane passes its bytes through in order.
- R2: Output byte k of a packet is byte k/N of lane k mod N, where N is the active lane count. Byte k of the packet is therefore reproduced exactly and in order.
- R3: A lane whose first byte arrives up to cfg_skew cycles after the earliest lane's first byte is aligned. The packet is output unchanged and align_err stays low.
- R4: If some active lane has not started by the time cfg_skew cycles have passed since the earliest start, align_err pulses high for exactly one cycle. No byte of that packet is output, and the next packet is merged normally.
- R5: An active lane that never starts a packet produces the same result as R4: a single align_err pulse and no output bytes.
- R6: When the packet length is not a multiple of N, the packet still ends on its true last byte, without waiting for bytes on the shorter lanes.
- R7: out_sop is high only on the first byte of a packet and out_eop only on its last byte. After the last byte is accepted, out_valid drops.
- R8: While out_valid is high and out_ready low, out_valid, out_data, out_sop and out_eop hold. No byte is lost or repeated, and no byte leaves while out_ready stays low.
- R9: After reset, out_valid and align_err are low.
- R10: A lane buffer is never written while full, as long as each lane carries at most DEPTH bytes per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lanes | input | 4 | Number of active lanes, 1 to 8 |
| cfg_skew | input | 3 | Skew window in cycles after the earliest lane start |
| lane_valid | input | 8 | Per-lane byte valid |
| lane_data | input | 64 | Per-lane byte, lane n in bits 8n+7:8n |
| lane_first | input | 8 | Per-lane first byte of the packet |
| lane_last | input | 8 | Per-lane last byte of the packet |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | Merged byte available |
| out_data | output | 8 | Merged byte |
| out_sop | output | 1 | First byte of the packet |
| out_eop | output | 1 | Last byte of the packet |
| align_err | output | 1 | One-cycle pulse: packet discarded for misalignment |

## Verification
The merge is tried with every lane count from one to eight. Packet lengths are both multiples and non-multiples of the lane count, so the short-lane end logic and the rotation wrap are both exercised. Lane start offsets are random within the window and also set exactly at the window edge, then one cycle past it, and one lane is left out entirely. This separates alignment that works from an error pulse that fires too early or too late. A fully stalled output and random ready patterns separate a correct hold from lost or repeated bytes. Noise on inactive lanes shows whether the lane count masks them.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DROP   = 2'd3
    } merge_state_e;
endpackage

// File: rtl/lm_lane_fifo.sv
`timescale 1ns/1ps
module lm_lane_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end

    assign rd_data = mem[rp];
endmodule

// File: rtl/lm_rr_pick.sv
`timescale 1ns/1ps
module lm_rr_pick #(
    parameter int LANES  = 8,
    parameter int CNT_W  = 5,
    parameter int LANE_W = 3
) (
    input  logic [LANES-1:0][7:0]       heads,
    input  logic [LANES-1:0][CNT_W-1:0] counts,
    input  logic [LANES-1:0]            ended,
    input  logic [LANE_W-1:0]           cur_lane,
    input  logic [LANE_W-1:0]           nxt_lane,
    output logic                        cur_has,
    output logic [7:0]                  cur_byte,
    output logic                        nxt_has,
    output logic                        nxt_done
);
    always_comb begin
        cur_has  = (counts[cur_lane] != '0);
        cur_byte = heads[cur_lane];
        if (cur_lane == nxt_lane) begin
            // single lane: the following byte sits behind the current one
            nxt_has  = (counts[cur_lane] > CNT_W'(1));
            nxt_done = ended[cur_lane] && (counts[cur_lane] == CNT_W'(1));
        end else begin
            nxt_has  = (counts[nxt_lane] != '0);
            nxt_done = ended[nxt_lane] && (counts[nxt_lane] == '0);
        end
    end
endmodule

// File: rtl/lane_merger.sv
`timescale 1ns/1ps
module lane_merger #(
    parameter int MAX_LANES = 8,
    parameter int DEPTH     = 16,
    parameter int SKEW_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(MAX_LANES+1)-1:0]    cfg_lanes,
    input  logic [SKEW_W-1:0]                 cfg_skew,
    input  logic [MAX_LANES-1:0]              lane_valid,
    input  logic [MAX_LANES*lm_pkg::BYTE_W-1:0] lane_data,
    input  logic [MAX_LANES-1:0]              lane_first,
    input  logic [MAX_LANES-1:0]              lane_last,
    input  logic                              out_ready,
    output logic                              out_valid,
    output logic [lm_pkg::BYTE_W-1:0]         out_data,
    output logic                              out_sop,
    output logic                              out_eop,
    output logic                              align_err
);
    import lm_pkg::*;

    localparam int LANE_W = $clog2(MAX_LANES);
    localparam int CFG_W  = $clog2(MAX_LANES+1);
    localparam int CNT_W  = $clog2(DEPTH+1);

    merge_state_e state, state_nx;

    logic [CFG_W-1:0]  n_eff;
    logic [LANE_W-1:0] last_lane, lp, nxt_lane;
    logic [MAX_LANES-1:0] active, started, ended;
    logic [MAX_LANES-1:0] sop_hit, end_hit, started_nx, ended_nx;
    logic [MAX_LANES-1:0] wr_en, rd_en;
    logic [MAX_LANES-1:0][BYTE_W-1:0] heads;
    logic [MAX_LANES-1:0][CNT_W-1:0]  fifo_cnt;
    logic [SKEW_W-1:0] skew_cnt;
    logic accept_start, all_in, open_any, err_nx, first_q, pop;
    logic cur_has, nxt_has, nxt_done;
    logic [BYTE_W-1:0] cur_byte;

    // lane count limited to the range the hardware has
    assign n_eff = (cfg_lanes == '0) ? CFG_W'(1) :
                   (cfg_lanes > CFG_W'(MAX_LANES)) ? CFG_W'(MAX_LANES) : cfg_lanes;
    assign last_lane = LANE_W'(n_eff - 1'b1);
    assign nxt_lane  = (lp == last_lane) ? '0 : lp + 1'b1;

    genvar g;
    generate
        for (g = 0; g < MAX_LANES; g++) begin : g_lane
            assign active[g] = (CFG_W'(g) < n_eff);
            assign rd_en[g]  = pop && (lp == LANE_W'(g));
            lm_lane_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (state == ST_DROP),
                .wr_en   (wr_en[g]),
                .wr_data (lane_data[g*BYTE_W +: BYTE_W]),
                .rd_en   (rd_en[g]),
                .rd_data (heads[g]),
                .count   (fifo_cnt[g])
            );
        end
    endgenerate

    lm_rr_pick #(.LANES(MAX_LANES), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_pick (
        .heads    (heads),
        .counts   (fifo_cnt),
        .ended    (ended),
        .cur_lane (lp),
        .nxt_lane (nxt_lane),
        .cur_has  (cur_has),
        .cur_byte (cur_byte),
        .nxt_has  (nxt_has),
        .nxt_done (nxt_done)
    );

    // lane start / end bookkeeping and buffer writes
    always_comb begin
        sop_hit      = lane_valid & lane_first & active;
        accept_start = (state == ST_IDLE) || (state == ST_SYNC);
        started_nx   = (state == ST_STREAM) ? started : (started | sop_hit);
        wr_en        = lane_valid & active & ~ended &
                       (started | (sop_hit & {MAX_LANES{accept_start}})) &
                       {MAX_LANES{state != ST_DROP}};
        end_hit      = lane_valid & lane_last & active & started_nx;
        ended_nx     = ended | end_hit;
        all_in       = ((started_nx & active) == active);
        open_any     = |(started_nx & ~ended_nx);
    end

    // next state
    always_comb begin
        state_nx = state;
        err_nx   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (|sop_hit) begin
                    if (all_in) begin
                        state_nx = ST_STREAM;
                    end else if (cfg_skew == '0) begin
                        state_nx = ST_DROP;
                        err_nx   = 1'b1;
                    end else begin
                        state_nx = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (all_in) begin
                    state_nx = ST_STREAM;
                end else if (skew_cnt >= cfg_skew) begin
                    state_nx = ST_DROP;
                    err_nx   = 1'b1;
                end
            end
            ST_STREAM: begin
                if (pop && out_eop) state_nx = ST_IDLE;
            end
            ST_DROP: begin
                if (!open_any) state_nx = ST_IDLE;
            end
        endcase
    end

    // state register and controller state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            started   <= '0;
            ended     <= '0;
            skew_cnt  <= '0;
            lp        <= '0;
            first_q   <= 1'b1;
            align_err <= 1'b0;
        end else begin
            state     <= state_nx;
            align_err <= err_nx;
            if (state_nx == ST_IDLE) begin
                started <= '0;
                ended   <= '0;
            end else begin
                started <= started_nx;
                ended   <= ended_nx;
            end
            if (state == ST_IDLE)      skew_cnt <= SKEW_W'(1);
            else if (state == ST_SYNC) skew_cnt <= skew_cnt + 1'b1;
            if (state != ST_STREAM) begin
                lp      <= '0;
                first_q <= 1'b1;
            end else if (pop) begin
                lp      <= nxt_lane;
                first_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_STREAM) && cur_has && (nxt_has || nxt_done);
        out_data  = cur_byte;
        out_sop   = out_valid && first_q;
        out_eop   = out_valid && nxt_done;
        pop       = out_valid && out_ready;
    end
endmodule

// File: rtl/lm_checker.sv
`timescale 1ns/1ps
module lm_checker #(
    parameter int MAX_LANES = 8,
    parameter int DEPTH     = 16
) (
    input logic                                       clk,
    input logic                                       rst_n,
    input logic                                       out_valid,
    input logic                                       out_ready,
    input logic [7:0]                                 out_data,
    input logic                                       out_sop,
    input logic                                       out_eop,
    input logic                                       align_err,
    input logic [MAX_LANES-1:0]                       wr_en,
    input logic [MAX_LANES-1:0][$clog2(DEPTH+1)-1:0]  fifo_cnt
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [MAX_LANES-1:0] full;
    genvar g;
    generate
        for (g = 0; g < MAX_LANES; g++) begin : g_full
            assign full[g] = (fifo_cnt[g] == CNT_W'(DEPTH));
        end
    endgenerate

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_sop) && $stable(out_eop)));

    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> !align_err);

    assert_err_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !out_valid);

    assert_eop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & full) == '0);
endmodule

bind lane_merger lm_checker #(.MAX_LANES(MAX_LANES), .DEPTH(DEPTH)) u_lm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .align_err (align_err),
    .wr_en     (wr_en),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/lane_merger_bench.sv
`timescale 1ns/1ps
module lane_merger_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_lanes = 4'd4;
    logic [2:0]  cfg_skew = 3'd3;
    logic [7:0]  lane_valid = '0;
    logic [63:0] lane_data = '0;
    logic [7:0]  lane_first = '0;
    logic [7:0]  lane_last = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_sop, out_eop, align_err;
    logic [7:0]  out_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] rx_data [256];
    bit         rx_sop  [256];
    bit         rx_eop  [256];
    int rx_n = 0;
    int err_seen = 0;
    bit rx_done = 0;
    int rdy_pct = 100;
    bit stall = 0;
    bit noise = 1;
    int sk [8];

    lane_merger u_lane_merger (
        .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .cfg_skew(cfg_skew),
        .lane_valid(lane_valid), .lane_data(lane_data), .lane_first(lane_first),
        .lane_last(lane_last), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .align_err(align_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int pk, input int i);
        return 8'(pk * 37 + i * 13 + 5);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // output side: random ready, capture, hold check (R8)
    initial begin
        logic [7:0] held;
        bit was_st;
        was_st = 0;
        held = '0;
        forever begin
            @(negedge clk);
            out_ready = !stall && (int'($urandom_range(99)) < rdy_pct);
            #1;
            if (rst_n) begin
                if (was_st) chk(out_valid && out_data == held, "R8 hold", int'(out_data), int'(held));
                if (align_err) err_seen++;
                if (out_valid && out_ready) begin
                    if (rx_n < 256) begin
                        rx_data[rx_n] = out_data;
                        rx_sop[rx_n]  = out_sop;
                        rx_eop[rx_n]  = out_eop;
                    end
                    rx_n++;
                    if (out_eop) rx_done = 1;
                end
                was_st = out_valid && !out_ready;
                held = out_data;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic clear_rx();
        rx_n = 0;
        err_seen = 0;
        rx_done = 0;
    endtask

    task automatic send_pkt(input int nl, input int len, input int pk, input int omit);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            for (int l = 0; l < 8; l++) begin
                lane_valid[l] = 1'b0;
                lane_first[l] = 1'b0;
                lane_last[l]  = 1'b0;
                lane_data[l*8 +: 8] = 8'h00;
                if (l < nl) begin
                    int nb;
                    int idx;
                    nb  = (len - l + nl - 1) / nl;
                    idx = t - sk[l];
                    if (l != omit && idx >= 0 && idx < nb) begin
                        lane_valid[l] = 1'b1;
                        lane_data[l*8 +: 8] = exp_byte(pk, idx * nl + l);
                        lane_first[l] = (idx == 0);
                        lane_last[l]  = (idx == nb - 1);
                    end
                end else if (noise) begin
                    lane_valid[l] = 1'($urandom_range(1));
                    lane_first[l] = 1'($urandom_range(1));
                    lane_last[l]  = 1'($urandom_range(1));
                    lane_data[l*8 +: 8] = 8'($urandom);
                end
            end
        end
        @(negedge clk);
        lane_valid = '0;
        lane_first = '0;
        lane_last  = '0;
    endtask

    task automatic check_good(input int pk, input int len, input string req);
        int mism, bad_i, sops, eops;
        for (int c = 0; c < 400 && !rx_done; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rx_n == len, {req, " length"}, rx_n, len);
        mism = 0; bad_i = -1; sops = 0; eops = 0;
        for (int i = 0; i < len && i < 256; i++) begin
            if (rx_data[i] != exp_byte(pk, i)) begin
                mism++;
                if (bad_i < 0) bad_i = i;
            end
            if (rx_sop[i]) sops++;
            if (rx_eop[i]) eops++;
        end
        if (bad_i >= 0)
            chk(0, {req, " byte order"}, int'(rx_data[bad_i]), int'(exp_byte(pk, bad_i)));
        else
            chk(1, {req, " byte order"}, 0, 0);
        chk(rx_sop[0] && sops == 1, "R7 sop marker", sops, 1);
        chk(len > 0 && rx_eop[len-1] && eops == 1, "R7 eop marker", eops, 1);
        chk(err_seen == 0, {req, " no align_err"}, err_seen, 0);
    endtask

    task automatic check_bad(input string req);
        repeat (60) @(negedge clk);
        chk(err_seen == 1, {req, " one align_err pulse"}, err_seen, 1);
        chk(rx_n == 0, {req, " nothing output"}, rx_n, 0);
    endtask

    task automatic set_skews(input int a, input int b, input int c, input int d);
        for (int l = 0; l < 8; l++) sk[l] = 0;
        sk[0] = a; sk[1] = b; sk[2] = c; sk[3] = d;
    endtask

    initial begin
        int pk;
        void'($urandom(32'd20240611));
        pk = 1;
        for (int l = 0; l < 8; l++) sk[l] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        chk(align_err == 1'b0, "R9 align_err after reset", int'(align_err), 0);

        // R2: four lanes, aligned, multiple length, always ready
        cfg_lanes = 4'd4; cfg_skew = 3'd3; rdy_pct = 100;
        set_skews(0, 0, 0, 0);
        clear_rx(); send_pkt(4, 16, pk, -1); check_good(pk, 16, "R2"); pk++;

        // R6: length not a multiple of the lane count
        clear_rx(); send_pkt(4, 9, pk, -1); check_good(pk, 9, "R6"); pk++;
        clear_rx(); send_pkt(4, 7, pk, -1); check_good(pk, 7, "R6"); pk++;

        // R3: skew exactly at the window edge, eight lanes
        cfg_lanes = 4'd8; cfg_skew = 3'd3;
        for (int l = 0; l < 8; l++) sk[l] = l % 4;
        clear_rx(); send_pkt(8, 45, pk, -1); check_good(pk, 45, "R3"); pk++;

        // R1: single lane with noise on all others
        cfg_lanes = 4'd1;
        for (int l = 0; l < 8; l++) sk[l] = 0;
        clear_rx(); send_pkt(1, 5, pk, -1); check_good(pk, 5, "R1"); pk++;

        // R1: three lanes, noise on lanes 3..7
        cfg_lanes = 4'd3; rdy_pct = 70;
        clear_rx(); send_pkt(3, 20, pk, -1); check_good(pk, 20, "R1"); pk++;

        // R4: one lane a cycle past the window, then recovery
        cfg_lanes = 4'd4; cfg_skew = 3'd2; rdy_pct = 100;
        set_skews(0, 0, 3, 0);
        clear_rx(); send_pkt(4, 16, pk, -1); check_bad("R4"); pk++;
        set_skews(0, 2, 0, 1);
        clear_rx(); send_pkt(4, 16, pk, -1); check_good(pk, 16, "R4 recovery"); pk++;

        // R5: a lane that never starts
        cfg_lanes = 4'd3; cfg_skew = 3'd3;
        set_skews(0, 0, 0, 0);
        clear_rx(); send_pkt(3, 12, pk, 1); check_bad("R5"); pk++;
        clear_rx(); send_pkt(3, 12, pk, -1); check_good(pk, 12, "R5 recovery"); pk++;

        // R3 / R4 with a zero window
        cfg_lanes = 4'd2; cfg_skew = 3'd0;
        set_skews(0, 0, 0, 0);
        clear_rx(); send_pkt(2, 10, pk, -1); check_good(pk, 10, "R3 zero window"); pk++;
        set_skews(0, 1, 0, 0);
        clear_rx(); send_pkt(2, 10, pk, -1); check_bad("R4 zero window"); pk++;

        // R8: output fully stalled while the whole packet arrives
        cfg_lanes = 4'd4; cfg_skew = 3'd3;
        set_skews(1, 0, 2, 0);
        stall = 1;
        clear_rx(); send_pkt(4, 40, pk, -1);
        chk(rx_n == 0, "R8 nothing while stalled", rx_n, 0);
        stall = 0;
        check_good(pk, 40, "R8"); pk++;

        // random mix: R2 R3 R6 R1
        cfg_skew = 3'd3;
        for (int k = 0; k < 40; k++) begin
            int nl, len;
            nl = 1 + int'($urandom_range(7));
            len = nl + int'($urandom_range(nl * 11));
            cfg_lanes = 4'(nl);
            rdy_pct = 50 + int'($urandom_range(50));
            for (int l = 0; l < 8; l++) sk[l] = int'($urandom_range(3));
            clear_rx(); send_pkt(nl, len, pk, -1); check_good(pk, len, "R2 random"); pk++;
        end

        finish_run();
    end
endmodule